// File: doc/BRIEF.md
# Sobel Edge Decision Pipeline

This block turns one 3x3 neighbourhood of unsigned grey-level pixels into an edge verdict for the centre pixel. For each accepted window it forms signed gradients along four orientations: two diagonals, the vertical and the horizontal. It takes the strongest gradient and adds one eighth of the gradient across it. If that total reaches a threshold, the pixel is marked as an edge and given one of eight compass directions. The direction always points toward the brighter side.

A line-buffer stage upstream supplies a complete window and a valid strobe, at up to one window per clock. Three clock cycles later the block returns an edge flag, a 3-bit direction code and a binary output pixel. Gaps in the valid strobe pass through the pipeline unchanged.

Top module: `sobel_edge_decide`

## Requirements
- R1: The window pixel at row r, column c (row 0 at the top) sits at in_win bits [(3r+c)*8 +: 8]. The four gradients are computed from it in signed arithmetic:
  - Diagonal-up: (t01 + 2*t02 + t12) - (t10 + 2*t20 + t21)
  - Vertical: (t00 + 2*t01 + t02) - (t20 + 2*t21 + t22)
  - Horizontal: (t02 + 2*t12 + t22) - (t00 + 2*t10 + t20)
  - Diagonal-down: (t10 + 2*t00 + t01) - (t21 + 2*t22 + t12)
- R2: The winning orientation has the largest absolute gradient. On equal magnitudes the earlier orientation wins, in the order diagonal-up, vertical, horizontal, diagonal-down.
- R3: The direction code comes from the winner's sign. A gradient of zero or more picks the first direction of the pair and a negative one picks the second. The pairs are diagonal-up NE/SW, vertical N/S, horizontal E/W and diagonal-down NW/SE. The codes are NW=0, N=1, NE=2, E=3, SE=4, S=5, SW=6, W=7.
- R4: The cross term is the absolute gradient of the orthogonal orientation: vertical with horizontal, and diagonal-up with diagonal-down. It is shifted right by 3, truncating, before it is added to the winning magnitude.
- R5: out_edge is 1 exactly when the winning magnitude plus the cross term is at least THRESH (default 80). When out_edge is 0, out_dir is 0.
- R6: out_pix is 255 when out_edge is 1 and 0 otherwise.
- R7: out_valid repeats in_valid exactly three clock cycles later, including gaps. Back-to-back windows are each accepted on consecutive cycles.
- R8: While rst is high, and in the cycles before any valid window has reached the output, out_valid, out_edge, out_dir and out_pix are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Window on in_win is to be processed |
| in_win | input | 72 | Nine 8-bit pixels, row-major from the top-left |
| out_valid | output | 1 | Result outputs carry a verdict |
| out_edge | output | 1 | Centre pixel is an edge |
| out_dir | output | 3 | Direction toward the brighter side, 0 when not an edge |
| out_pix | output | 8 | Binary output pixel, 255 or 0 |

## Verification
The hardest situation to reach is one where the cross term alone decides the verdict. That needs a winning magnitude just below the threshold and a large orthogonal gradient, which flat or random full-range windows almost never produce. The stimulus reaches it with exhaustive two-level windows at low contrast (levels 20 and 23), which place gradients in multiples near 80 with sizeable cross terms. It adds a random sweep limited to pixel values 0 to 63, plus half-plane steps in all eight directions with a rising step height. Equal-magnitude ties and exact-threshold hits occur many times within the two-level sweep.

// File: rtl/sobel_pkg.sv
package sobel_pkg;

    // Compass codes for the output direction
    typedef enum logic [2:0] {
        DIR_NW = 3'd0,
        DIR_N  = 3'd1,
        DIR_NE = 3'd2,
        DIR_E  = 3'd3,
        DIR_SE = 3'd4,
        DIR_S  = 3'd5,
        DIR_SW = 3'd6,
        DIR_W  = 3'd7
    } dir_e;

    // Orientation index; the order is also the tie-break priority
    typedef enum logic [1:0] {
        ORI_DIAG_UP   = 2'd0,
        ORI_VERT      = 2'd1,
        ORI_HORZ      = 2'd2,
        ORI_DIAG_DOWN = 2'd3
    } orient_e;

    localparam int NUM_ORI = 4;

    // Orthogonal partner: 0<->3, 1<->2
    function automatic orient_e ortho_of(input orient_e o);
        return orient_e'(~o);
    endfunction

    // Sign of the winning gradient picks one side of its orientation
    function automatic dir_e dir_of(input orient_e o, input logic neg);
        dir_e d;
        unique case (o)
            ORI_DIAG_UP:   d = neg ? DIR_SW : DIR_NE;
            ORI_VERT:      d = neg ? DIR_S  : DIR_N;
            ORI_HORZ:      d = neg ? DIR_W  : DIR_E;
            ORI_DIAG_DOWN: d = neg ? DIR_SE : DIR_NW;
            default:       d = DIR_NW;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/sobel_deriv.sv
module sobel_deriv
    import sobel_pkg::*;
#(
    parameter  int PIX_W = 8,
    localparam int DER_W = PIX_W + 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [9*PIX_W-1:0]      in_win,
    output logic                    d_valid,
    output logic signed [DER_W-1:0] d_q [NUM_ORI]
);

    localparam logic signed [DER_W-1:0] D_MAX = DER_W'(4 * ((1 << PIX_W) - 1));
    localparam logic signed [DER_W-1:0] D_MIN = -D_MAX;

    logic signed [DER_W-1:0] px [3][3];
    logic signed [DER_W-1:0] d_n [NUM_ORI];

    for (genvar r = 0; r < 3; r++) begin : g_row
        for (genvar c = 0; c < 3; c++) begin : g_col
            assign px[r][c] = $signed({{(DER_W-PIX_W){1'b0}},
                                       in_win[(3*r+c)*PIX_W +: PIX_W]});
        end
    end

    always_comb begin
        d_n[ORI_DIAG_UP]   = (px[0][1] + (px[0][2] <<< 1) + px[1][2])
                           - (px[1][0] + (px[2][0] <<< 1) + px[2][1]);
        d_n[ORI_VERT]      = (px[0][0] + (px[0][1] <<< 1) + px[0][2])
                           - (px[2][0] + (px[2][1] <<< 1) + px[2][2]);
        d_n[ORI_HORZ]      = (px[0][2] + (px[1][2] <<< 1) + px[2][2])
                           - (px[0][0] + (px[1][0] <<< 1) + px[2][0]);
        d_n[ORI_DIAG_DOWN] = (px[1][0] + (px[0][0] <<< 1) + px[0][1])
                           - (px[2][1] + (px[2][2] <<< 1) + px[1][2]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            d_valid <= 1'b0;
            for (int i = 0; i < NUM_ORI; i++) d_q[i] <= '0;
        end else begin
            d_valid <= in_valid;
            for (int i = 0; i < NUM_ORI; i++) d_q[i] <= d_n[i];
        end
    end

    for (genvar g = 0; g < NUM_ORI; g++) begin : g_chk
        AST_DERIV_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
            d_valid |-> (d_q[g] <= D_MAX && d_q[g] >= D_MIN)); // R1
    end

endmodule

// File: rtl/sobel_pick.sv
module sobel_pick
    import sobel_pkg::*;
#(
    parameter  int PIX_W = 8,
    localparam int DER_W = PIX_W + 4,
    localparam int MAG_W = PIX_W + 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    d_valid,
    input  logic signed [DER_W-1:0] d_in [NUM_ORI],
    output logic                    p_valid,
    output logic [MAG_W-1:0]        p_max,
    output logic [MAG_W-1:0]        p_perp,
    output dir_e                    p_dir
);

    logic [MAG_W-1:0] mag [NUM_ORI];
    orient_e          best;
    logic [MAG_W-1:0] max_n;
    logic [MAG_W-1:0] perp_n;
    dir_e             dir_n;

    for (genvar g = 0; g < NUM_ORI; g++) begin : g_abs
        logic signed [DER_W-1:0] negated;
        assign negated = -d_in[g];
        assign mag[g]  = d_in[g][DER_W-1] ? negated[MAG_W-1:0] : d_in[g][MAG_W-1:0];
    end

    // Strict compare keeps the earliest orientation on ties
    always_comb begin
        best = ORI_DIAG_UP;
        for (int i = 1; i < NUM_ORI; i++) begin
            if (mag[i] > mag[best]) best = orient_e'(i);
        end
        max_n  = mag[best];
        perp_n = mag[ortho_of(best)];
        dir_n  = dir_of(best, d_in[best][DER_W-1]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            p_valid <= 1'b0;
            p_max   <= '0;
            p_perp  <= '0;
            p_dir   <= DIR_NW;
        end else begin
            p_valid <= d_valid;
            p_max   <= max_n;
            p_perp  <= perp_n;
            p_dir   <= dir_n;
        end
    end

    AST_MAX_DOMINATES: assert property (@(posedge clk) disable iff (rst)
        p_valid |-> p_max >= p_perp); // R2

endmodule

// File: rtl/sobel_thresh.sv
module sobel_thresh
    import sobel_pkg::*;
#(
    parameter  int PIX_W  = 8,
    parameter  int THRESH = 80,
    localparam int MAG_W  = PIX_W + 3,
    localparam int SUM_W  = MAG_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             p_valid,
    input  logic [MAG_W-1:0] p_max,
    input  logic [MAG_W-1:0] p_perp,
    input  dir_e             p_dir,
    output logic             q_valid,
    output logic             q_edge,
    output logic [2:0]       q_dir,
    output logic [PIX_W-1:0] q_pix
);

    localparam logic [SUM_W-1:0] THR = SUM_W'(THRESH);

    logic [SUM_W-1:0] score;
    logic             hit;

    assign score = {1'b0, p_max} + SUM_W'(p_perp >> 3);
    assign hit   = (score >= THR);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_valid <= 1'b0;
            q_edge  <= 1'b0;
            q_dir   <= '0;
            q_pix   <= '0;
        end else begin
            q_valid <= p_valid;
            q_edge  <= p_valid && hit;
            q_dir   <= (p_valid && hit) ? p_dir : 3'd0;
            q_pix   <= (p_valid && hit) ? '1 : '0;
        end
    end

    AST_NONEDGE_DIR_ZERO: assert property (@(posedge clk) disable iff (rst)
        !q_edge |-> q_dir == 3'd0); // R5

    AST_STRONG_MAX_IS_EDGE: assert property (@(posedge clk) disable iff (rst)
        (q_valid && !q_edge) |-> ({1'b0, $past(p_max)} < THR)); // R5

    AST_PIX_FOLLOWS_EDGE: assert property (@(posedge clk) disable iff (rst)
        q_edge == (q_pix != '0)); // R6

endmodule

// File: rtl/sobel_edge_decide.sv
module sobel_edge_decide
    import sobel_pkg::*;
#(
    parameter  int PIX_W  = 8,
    parameter  int THRESH = 80,
    localparam int DER_W  = PIX_W + 4,
    localparam int MAG_W  = PIX_W + 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [9*PIX_W-1:0] in_win,
    output logic               out_valid,
    output logic               out_edge,
    output logic [2:0]         out_dir,
    output logic [PIX_W-1:0]   out_pix
);

    logic                    s1_valid;
    logic signed [DER_W-1:0] s1_d [NUM_ORI];
    logic                    s2_valid;
    logic [MAG_W-1:0]        s2_max;
    logic [MAG_W-1:0]        s2_perp;
    dir_e                    s2_dir;

    sobel_deriv #(.PIX_W(PIX_W)) u_deriv (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_win   (in_win),
        .d_valid  (s1_valid),
        .d_q      (s1_d)
    );

    sobel_pick #(.PIX_W(PIX_W)) u_pick (
        .clk     (clk),
        .rst     (rst),
        .d_valid (s1_valid),
        .d_in    (s1_d),
        .p_valid (s2_valid),
        .p_max   (s2_max),
        .p_perp  (s2_perp),
        .p_dir   (s2_dir)
    );

    sobel_thresh #(.PIX_W(PIX_W), .THRESH(THRESH)) u_thresh (
        .clk     (clk),
        .rst     (rst),
        .p_valid (s2_valid),
        .p_max   (s2_max),
        .p_perp  (s2_perp),
        .p_dir   (s2_dir),
        .q_valid (out_valid),
        .q_edge  (out_edge),
        .q_dir   (out_dir),
        .q_pix   (out_pix)
    );

    // Independent record of the input strobe for the latency check
    logic [2:0] vhist;
    always_ff @(posedge clk) begin
        if (rst) vhist <= '0;
        else     vhist <= {vhist[1:0], in_valid};
    end

    AST_VALID_DELAY: assert property (@(posedge clk) disable iff (rst)
        out_valid == vhist[2]); // R7

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && !out_edge && out_pix == '0)); // R8

endmodule

// File: tb/sobel_edge_decide_test.sv
`timescale 1ns/1ps
module sobel_edge_decide_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [71:0] in_win = '0;
    logic        out_valid;
    logic        out_edge;
    logic [2:0]  out_dir;
    logic [7:0]  out_pix;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;

    // ring of expected results: {valid, edge, dir[2:0], pix[7:0]}
    logic [12:0] ring [4];

    always #2 clk = ~clk;

    sobel_edge_decide uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_win(in_win),
        .out_valid(out_valid), .out_edge(out_edge), .out_dir(out_dir), .out_pix(out_pix)
    );

    function automatic int px(input logic [71:0] w, input int r, input int c);
        return int'(w[(3*r+c)*8 +: 8]);
    endfunction

    // Reference verdict from the requirements: {edge, dir, pix}
    function automatic logic [11:0] model(input logic [71:0] w);
        int d [4];
        int m [4];
        int best;
        int perp;
        int total;
        int dirc;
        int pos_code [4] = '{2, 1, 3, 0};
        int neg_code [4] = '{6, 5, 7, 4};
        d[0] = (px(w,0,1) + 2*px(w,0,2) + px(w,1,2)) - (px(w,1,0) + 2*px(w,2,0) + px(w,2,1));
        d[1] = (px(w,0,0) + 2*px(w,0,1) + px(w,0,2)) - (px(w,2,0) + 2*px(w,2,1) + px(w,2,2));
        d[2] = (px(w,0,2) + 2*px(w,1,2) + px(w,2,2)) - (px(w,0,0) + 2*px(w,1,0) + px(w,2,0));
        d[3] = (px(w,1,0) + 2*px(w,0,0) + px(w,0,1)) - (px(w,2,1) + 2*px(w,2,2) + px(w,1,2));
        for (int i = 0; i < 4; i++) m[i] = (d[i] < 0) ? -d[i] : d[i];
        best = 0;
        for (int i = 1; i < 4; i++) if (m[i] > m[best]) best = i;
        perp  = m[3 - best];
        total = m[best] + perp / 8;
        dirc  = (d[best] < 0) ? neg_code[best] : pos_code[best];
        if (total >= 80) return {1'b1, 3'(dirc), 8'd255};
        return 12'd0;
    endfunction

    task automatic check(input string tag, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fails++;
            $display("FAIL %s at cycle %0d: got %0d expected %0d", tag, cyc, got, exp);
        end
    endtask

    // One cycle: check the result due now, then present the next window
    task automatic tick(input logic v, input logic [71:0] w);
        logic [12:0] due;
        logic [11:0] e;
        @(negedge clk);
        due = ring[(cyc + 1) % 4];
        check("R7 out_valid", int'(out_valid), int'(due[12]));
        if (due[12]) begin
            check("R5 out_edge", int'(out_edge), int'(due[11]));
            check("R3 R2 R4 out_dir", int'(out_dir), int'(due[10:8]));
            check("R6 out_pix", int'(out_pix), int'(due[7:0]));
        end
        e = model(w);
        ring[cyc % 4] = {v, e};
        in_valid = v;
        in_win   = w;
        cyc++;
    endtask

    function automatic logic [71:0] masked(input int mask, input int hi, input int lo);
        logic [71:0] w;
        for (int i = 0; i < 9; i++) w[i*8 +: 8] = 8'(mask[i] ? hi : lo);
        return w;
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL R7 watchdog expired at cycle %0d", cyc);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin : stim
        int pos_mask [4] = '{38, 7, 292, 11};
        int neg_mask [4] = '{200, 448, 73, 416};
        int lv [3] = '{255, 20, 23};
        logic [31:0] lfsr = 32'h1234_5678;
        logic [71:0] w;
        for (int i = 0; i < 4; i++) ring[i] = '0;

        // R8: quiet outputs while reset is held
        repeat (4) @(negedge clk);
        check("R8 out_valid in reset", int'(out_valid), 0);
        check("R8 out_edge in reset", int'(out_edge), 0);
        check("R8 out_dir in reset", int'(out_dir), 0);
        check("R8 out_pix in reset", int'(out_pix), 0);
        rst = 1'b0;
        tick(1'b0, '0);
        tick(1'b0, '0);
        check("R8 out_valid idle after reset", int'(out_valid), 0);

        // R1 R3: exact threshold hit and one below, then a flat window (zero gradients)
        w = '0; w[7:0] = 8'd20; w[15:8] = 8'd20; w[23:16] = 8'd20;
        tick(1'b1, w);
        w[15:8] = 8'd19; w[23:16] = 8'd21;
        tick(1'b1, w);
        tick(1'b1, {9{8'd77}});

        // R3: half-plane steps in all eight directions, rising step height
        for (int o = 0; o < 4; o++)
            for (int s = 0; s < 2; s++)
                for (int h = 0; h < 64; h++)
                    tick(1'b1, masked(s ? neg_mask[o] : pos_mask[o], 10 + 2*h, 10));

        // R2 R4 R5: exhaustive two-level windows at three contrasts
        for (int l = 0; l < 3; l++)
            for (int k = 0; k < 512; k++)
                tick(1'b1, masked(k, lv[l], 0));

        // R7: random windows with bubbles; first half low contrast
        for (int n = 0; n < 4000; n++) begin
            for (int i = 0; i < 9; i++) begin
                lfsr = lfsr ^ (lfsr << 13);
                lfsr = lfsr ^ (lfsr >> 17);
                lfsr = lfsr ^ (lfsr << 5);
                w[i*8 +: 8] = (n < 2000) ? {2'b00, lfsr[5:0]} : lfsr[7:0];
            end
            tick(lfsr[11:9] != 3'd0, w);
        end

        repeat (4) tick(1'b0, '0);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule